// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block sits on the host side of a one-bit-wide dynamic memory whose address pins are shared between row and column. A client hands it single-bit reads and writes with a 20-bit address through a valid/ready handshake. The controller produces the row strobe, column strobe, write strobe, the multiplexed 10-bit address, and the write-data enable. All timing comes from cycle-count parameters, so one netlist can serve any clock rate once the counts are set.

After an access the row stays open. A later request to the same row skips row activation and issues only a new column strobe. A request to another row closes the page, precharges, and opens the new row. A free-running interval timer requests a refresh often enough that every row is covered within the retention period. Each refresh uses the column-strobe-first method, so the memory's own row counter supplies the row and the controller drives no address.

Top module: `dram_page_ctrl`

## Requirements
- R1: The upper half of the request address, `req_addr[19:10]`, is the row and appears on `dram_addr` when `dram_ras_n` falls. The lower half, `req_addr[9:0]`, is the column and appears on `dram_addr` when `dram_cas_n` falls.
- R2: The row address is stable on `dram_addr` in the cycle before `dram_ras_n` falls. It is held for at least `T_RAH` cycles with the row strobe low before the bus changes to the column. The row strobe falls in the second cycle after a request is accepted on a closed page.
- R3: A write uses early write. `dram_we_n` is low and `dram_doe` high, with `dram_dout` equal to the request data, from the cycle before `dram_cas_n` falls until it rises.
- R4: A read keeps `dram_we_n` high and `dram_doe` low. `dram_din` is captured in the first cycle in which the column strobe has been low for at least `T_CAC` cycles and the row strobe for at least `T_RAC` cycles. `rsp_valid` pulses for one cycle in the next cycle, with that bit on `rsp_rdata`.
- R5: A request to the open row causes no new row-strobe fall. Its column strobe falls in the second cycle after acceptance.
- R6: A request to a row other than the open one makes the row strobe rise and stay high for at least `T_RP` cycles before the new row is strobed.
- R7: The refresh interval is `RETENTION_US*CLK_MHZ/REF_ROWS` cycles (3125 with the defaults). With no traffic, consecutive refresh row-strobe falls are exactly that many cycles apart.
- R8: A refresh drives `dram_cas_n` low for at least `T_CSR` cycles while `dram_ras_n` is high, then holds both low. While the column strobe is low with the row strobe high, `dram_we_n` is high and `dram_doe` is low.
- R9: A pending refresh beats new requests. It closes an open page and keeps the row strobe high for at least `T_RP` cycles before the refresh column strobe falls. `req_ready` stays low while a refresh is under way, and the first access afterwards must strobe its row again.
- R10: During and right after reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_doe` and `rsp_valid` are low, and `req_ready` is high.
- R11: Each access column-strobe pulse lasts at least `T_CAS` cycles. Between accesses in one page, the column strobe stays high for at least `T_CP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Row in upper half, column in lower half |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 1 | Read data bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_doe | output | 1 | Enable for the write-data driver |
| dram_dout | output | 1 | Write data to memory |
| dram_din | input | 1 | Read data from memory |

## Verification
The bench's memory model counts, cycle by cycle, how long each strobe has been low or high. It returns the stored bit only once both access counts are met and returns the inverted bit before that, so a capture that is early by one cycle gives wrong data. The read response is due exactly one cycle after the first cycle of valid data. From acceptance this comes to `2+T_CAC` cycles on a page hit and `3+T_RAH+max(T_CAC, T_RAC-T_RAH-1)` cycles on a closed page. The bench counts these on falling clock edges, away from the edge that updates the design. Refresh spacing is checked as an exact cycle distance between two idle refreshes. Scenarios that count row activations start right after a refresh, so no refresh can fall inside them.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

  // Sequencer phases; each maps to one fixed strobe pattern.
  typedef enum logic [3:0] {
    S_IDLE,     // page closed, strobes high
    S_ROW_SET,  // row placed on bus, row strobe still high
    S_RAS_ACT,  // row strobe low, row held
    S_COL_SET,  // column and write strobe placed
    S_CAS_ACT,  // column strobe low
    S_CAS_PRE,  // column strobe high inside the page
    S_OPEN,     // page open, waiting
    S_PRECH,    // row strobe high, precharging
    S_REF_CSR,  // refresh: column strobe low ahead of row strobe
    S_REF_RAS   // refresh: both strobes low
  } seq_state_e;

endpackage

// File: rtl/dctl_age_counter.sv
module dctl_age_counter #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_nxt,
  output logic [TW-1:0] age
);
  localparam logic [TW-1:0] AGE_MAX = {TW{1'b1}};

  logic [TW-1:0] age_d;

  always_comb begin
    if (!active_nxt)          age_d = '0;
    else if (age != AGE_MAX)  age_d = age + TW'(1);
    else                      age_d = age;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else        age <= age_d;
  end
endmodule

// File: rtl/dctl_refresh_timer.sv
module dctl_refresh_timer #(
  parameter int unsigned INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick, pend_d;

  assign tick   = (cnt_q == '0);
  assign cnt_d  = tick ? RELOAD : cnt_q - CW'(1);
  assign pend_d = tick | (pend & ~ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      pend  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pend  <= pend_d;
    end
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);
  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (cnt_q == RELOAD));
endmodule

// File: rtl/dctl_sequencer.sv
module dctl_sequencer
  import dctl_pkg::*;
#(
  parameter int unsigned MA_W  = 10,
  parameter int unsigned TW    = 8,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RAH = 2,
  parameter int unsigned T_CAS = 4,
  parameter int unsigned T_CAC = 3,
  parameter int unsigned T_RAC = 7,
  parameter int unsigned T_CP  = 2,
  parameter int unsigned T_CSR = 2,
  parameter int unsigned T_RFW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic              dram_doe,
  output logic              dram_dout,
  input  logic              dram_din
);
  localparam logic [TW-1:0] K_RP  = TW'(T_RP - 1);
  localparam logic [TW-1:0] K_RAH = TW'(T_RAH - 1);
  localparam logic [TW-1:0] K_CP  = TW'(T_CP - 1);
  localparam logic [TW-1:0] K_CSR = TW'(T_CSR - 1);
  localparam logic [TW-1:0] K_RFW = TW'(T_RFW - 1);
  localparam logic [TW-1:0] K_CAS = TW'(T_CAS);
  localparam logic [TW-1:0] K_CAC = TW'(T_CAC);
  localparam logic [TW-1:0] K_RAC = TW'(T_RAC);

  seq_state_e        state_q, state_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [MA_W-1:0]   row_q, col_q, cap_row, cap_col, in_row, in_col;
  logic              wr_q, wd_q, cap_wr, cap_wd;
  logic              smp_q, smp_d, rsp_v_d, rsp_b_d;
  logic              ras_d, cas_d, we_d, doe_d, dout_d;
  logic [MA_W-1:0]   addr_d;
  logic              hit, accept, take;
  logic [TW-1:0]     ras_age, cas_age;
  logic              ras_low_nxt, cas_low_nxt;

  assign in_row    = req_addr[2*MA_W-1:MA_W];
  assign in_col    = req_addr[MA_W-1:0];
  assign hit       = (state_q == S_OPEN) && (in_row == row_q);
  assign req_ready = !ref_pend && ((state_q == S_IDLE) || hit);
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (state_q == S_IDLE) && ref_pend;

  assign cap_row = accept ? in_row    : row_q;
  assign cap_col = accept ? in_col    : col_q;
  assign cap_wr  = accept ? req_write : wr_q;
  assign cap_wd  = accept ? req_wdata : wd_q;

  assign take = (state_q == S_CAS_ACT) && !wr_q && !smp_q &&
                (cas_age >= K_CAC) && (ras_age >= K_RAC);

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - TW'(1) : '0;
    smp_d   = smp_q;
    rsp_v_d = 1'b0;
    rsp_b_d = rsp_rdata;
    unique case (state_q)
      S_IDLE: begin
        if (ref_pend) begin
          state_d = S_REF_CSR;
          cnt_d   = K_CSR;
        end else if (accept) begin
          state_d = S_ROW_SET;
        end
      end
      S_ROW_SET: begin
        state_d = S_RAS_ACT;
        cnt_d   = K_RAH;
      end
      S_RAS_ACT: if (cnt_q == '0) state_d = S_COL_SET;
      S_COL_SET: begin
        state_d = S_CAS_ACT;
        smp_d   = 1'b0;
      end
      S_CAS_ACT: begin
        if (take) begin
          smp_d   = 1'b1;
          rsp_v_d = 1'b1;
          rsp_b_d = dram_din;
        end
        if ((cas_age >= K_CAS) && (wr_q || smp_q || take)) begin
          state_d = S_CAS_PRE;
          cnt_d   = K_CP;
        end
      end
      S_CAS_PRE: if (cnt_q == '0) state_d = S_OPEN;
      S_OPEN: begin
        if (ref_pend || (req_valid && !hit)) begin
          state_d = S_PRECH;
          cnt_d   = K_RP;
        end else if (accept) begin
          state_d = S_COL_SET;
        end
      end
      S_PRECH: if (cnt_q == '0) state_d = S_IDLE;
      S_REF_CSR: begin
        if (cnt_q == '0) begin
          state_d = S_REF_RAS;
          cnt_d   = K_RFW;
        end
      end
      S_REF_RAS: begin
        if (cnt_q == '0) begin
          state_d = S_PRECH;
          cnt_d   = K_RP;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // pin decode from the next state, registered below
  always_comb begin
    ras_d  = !(state_d inside {S_RAS_ACT, S_COL_SET, S_CAS_ACT, S_CAS_PRE,
                               S_OPEN, S_REF_RAS});
    cas_d  = !(state_d inside {S_CAS_ACT, S_REF_CSR, S_REF_RAS});
    addr_d = dram_addr;
    we_d   = 1'b1;
    doe_d  = 1'b0;
    dout_d = dram_dout;
    if (state_d inside {S_ROW_SET, S_RAS_ACT}) addr_d = cap_row;
    if (state_d inside {S_COL_SET, S_CAS_ACT}) begin
      addr_d = cap_col;
      we_d   = !cap_wr;
      doe_d  = cap_wr;
      if (cap_wr) dout_d = cap_wd;
    end
  end

  assign ras_low_nxt = ~ras_d;
  assign cas_low_nxt = ~cas_d;

  dctl_age_counter #(.TW(TW)) u_ras_age (
    .clk(clk), .rst_n(rst_n), .active_nxt(ras_low_nxt), .age(ras_age));
  dctl_age_counter #(.TW(TW)) u_cas_age (
    .clk(clk), .rst_n(rst_n), .active_nxt(cas_low_nxt), .age(cas_age));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      smp_q      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 1'b0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_addr  <= '0;
      dram_doe   <= 1'b0;
      dram_dout  <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      wd_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      smp_q      <= smp_d;
      rsp_valid  <= rsp_v_d;
      rsp_rdata  <= rsp_b_d;
      dram_ras_n <= ras_d;
      dram_cas_n <= cas_d;
      dram_we_n  <= we_d;
      dram_addr  <= addr_d;
      dram_doe   <= doe_d;
      dram_dout  <= dout_d;
      if (accept) begin
        row_q <= in_row;
        col_q <= in_col;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
    end
  end

  // R8
  cbr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && dram_ras_n) |-> (dram_we_n && !dram_doe));
  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_addr));
  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |->
      ($stable(dram_we_n) && $stable(dram_addr) && $stable(dram_dout)));
  // R11
  cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dram_cas_n) && !dram_ras_n) |-> ($past(cas_age) >= K_CAS));
  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int unsigned MA_W         = 10,
  parameter int unsigned TW           = 8,
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned RETENTION_US = 8000,
  parameter int unsigned REF_ROWS     = 512,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RAH        = 2,
  parameter int unsigned T_CAS        = 4,
  parameter int unsigned T_CAC        = 3,
  parameter int unsigned T_RAC        = 7,
  parameter int unsigned T_CP         = 2,
  parameter int unsigned T_CSR        = 2,
  parameter int unsigned T_RFW        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic              dram_doe,
  output logic              dram_dout,
  input  logic              dram_din
);
  localparam int unsigned REF_INTERVAL = RETENTION_US * CLK_MHZ / REF_ROWS;

  logic ref_pend, ref_ack;

  dctl_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend));

  dctl_sequencer #(
    .MA_W(MA_W), .TW(TW), .T_RP(T_RP), .T_RAH(T_RAH), .T_CAS(T_CAS),
    .T_CAC(T_CAC), .T_RAC(T_RAC), .T_CP(T_CP), .T_CSR(T_CSR), .T_RFW(T_RFW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_pend(ref_pend), .ref_ack(ref_ack),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_doe(dram_doe), .dram_dout(dram_dout),
    .dram_din(dram_din));
endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int T_RP = 3, T_RAH = 2, T_CAS = 4, T_CAC = 3, T_RAC = 7;
  localparam int T_CP = 2, T_CSR = 2;
  localparam int REF_INT = 8000 * 200 / 512;
  localparam int LAT_HIT  = 2 + T_CAC;
  localparam int LAT_MISS = 3 + T_RAH + ((T_CAC > T_RAC - T_RAH - 1) ? T_CAC : T_RAC - T_RAH - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [19:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_doe, dram_dout;
  logic [9:0] dram_addr;
  logic dram_din = 1'b0;

  always #2.5 clk = ~clk;

  dram_page_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
    .dram_doe(dram_doe), .dram_dout(dram_dout), .dram_din(dram_din));

  int n_cmp = 0, n_bad = 0;

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endfunction

  // ---------------- memory model and pin monitor (falling edges) ----------
  bit mem_m [int];
  bit shadow [int];
  int cyc = 0, act_cnt = 0, ref_cnt = 0, last_ref_cyc = 0, ref_gap = 0;
  int ras_lo = 0, cas_lo = 0, ras_hi = 1000, cas_hi = 1000, rowhold = 0;
  bit p_ras = 1, p_cas = 1, p_we = 1, p_doe = 0, p_dout = 0;
  logic [9:0] p_addr = '0, row_m = '0;
  bit in_ref = 0, cas_seen = 0, vld_seen = 0, exp_rsp = 0;
  int rd_key = 0;

  function automatic bit mget(input int k);
    return mem_m.exists(k) ? mem_m[k] : 1'b0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // R4: response exactly one cycle after data first valid
      if (exp_rsp) begin
        chk(rsp_valid, "R4 rsp timing", rsp_valid, 1);
        chk(rsp_rdata == mget(rd_key), "R4 rsp data", rsp_rdata, mget(rd_key));
        exp_rsp = 0;
      end else if (rsp_valid) chk(0, "R4 unexpected rsp", 1, 0);

      if (p_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          chk(cas_lo >= T_CSR, "R8 cas lead", cas_lo, T_CSR);
          chk(dram_we_n && !dram_doe, "R8 no write", dram_we_n, 1);
          in_ref = 1; ref_cnt++;
          ref_gap = cyc - last_ref_cyc; last_ref_cyc = cyc;
        end else begin
          chk(dram_addr == p_addr, "R2 row setup", dram_addr, p_addr);
          chk(ras_hi >= T_RP, "R6 precharge", ras_hi, T_RP);
          row_m = dram_addr; in_ref = 0; rowhold = 0; cas_seen = 0; act_cnt++;
        end
      end
      if (p_cas && !dram_cas_n) begin
        if (dram_ras_n) begin
          chk(ras_hi >= T_RP, "R9 precharge before refresh", ras_hi, T_RP);
        end else if (!in_ref) begin
          if (!cas_seen) chk(rowhold >= T_RAH, "R2 row hold", rowhold, T_RAH);
          else chk(cas_hi >= T_CP, "R11 cas precharge", cas_hi, T_CP);
          cas_seen = 1; vld_seen = 0;
          chk(dram_addr == p_addr && dram_we_n == p_we, "R3 setup", dram_we_n, p_we);
          if (!dram_we_n) begin
            chk(dram_doe && p_doe && dram_dout == p_dout, "R3 data setup", dram_doe, 1);
            mem_m[{row_m, dram_addr}] = dram_dout;
          end else begin
            chk(!dram_doe, "R4 no drive", dram_doe, 0);
            rd_key = {row_m, dram_addr};
          end
        end
      end else if (!p_cas && !dram_cas_n && !dram_ras_n && !in_ref && !dram_we_n)
        chk(dram_doe && dram_dout == p_dout, "R3 data hold", dram_dout, p_dout);
      if (!p_cas && dram_cas_n && !dram_ras_n && !in_ref)
        chk(cas_lo >= T_CAS, "R11 cas width", cas_lo, T_CAS);
      if (!dram_cas_n && dram_ras_n)
        chk(!req_ready, "R9 ready low in refresh", req_ready, 0);
    end

    ras_lo = dram_ras_n ? 0 : ras_lo + 1;
    ras_hi = dram_ras_n ? ras_hi + 1 : 0;
    cas_lo = dram_cas_n ? 0 : cas_lo + 1;
    cas_hi = dram_cas_n ? cas_hi + 1 : 0;
    if (!dram_ras_n && !in_ref && !cas_seen && dram_cas_n && dram_addr == row_m) rowhold++;

    if (rst_n && !dram_cas_n && !dram_ras_n && !in_ref && dram_we_n) begin
      if (cas_lo >= T_CAC && ras_lo >= T_RAC) begin
        dram_din = mget(rd_key);
        if (!vld_seen) begin vld_seen = 1; exp_rsp = 1; end
      end else dram_din = ~mget(rd_key);
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
    p_doe = dram_doe; p_dout = dram_dout; p_addr = dram_addr;
  end

  // ---------------- request helpers ----------------
  task automatic do_req(input bit wr, input int addr, input bit wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr[19:0]; req_wdata = wd;
    #0.1;
    while (!req_ready) begin @(negedge clk); #0.1; end
    @(posedge clk); #0.1;
    req_valid = 0;
    if (wr) shadow[addr] = wd;
  endtask

  task automatic do_read(input int addr, output bit d, output int lat);
    do_req(0, addr, 0);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 60);
    d = rsp_rdata;
  endtask

  task automatic wait_refresh();
    int r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  function automatic int mk(input int row, input int col);
    return (row << 10) | col;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!dram_doe && !rsp_valid, "R10 drive/rsp in reset", dram_doe, 0);
    rst_n = 1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes after reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(req_ready, "R10 ready after reset", req_ready, 1);
  endtask

  task automatic t_page_hit();
    bit d; int lat; int a0;
    wait_refresh();
    a0 = act_cnt;
    do_req(1, mk(21, 3), 1);
    do_req(1, mk(21, 8), 0);
    do_read(mk(21, 3), d, lat);
    chk(d == 1, "R5 hit read col3", d, 1);
    chk(lat == LAT_HIT, "R5 hit latency", lat, LAT_HIT);
    do_read(mk(21, 8), d, lat);
    chk(d == 0, "R5 hit read col8", d, 0);
    chk(act_cnt - a0 == 1, "R5 single row activation", act_cnt - a0, 1);
  endtask

  task automatic t_split_miss();
    bit d; int lat; int a0;
    wait_refresh();
    a0 = act_cnt;
    do_req(1, mk(3, 9), 1);
    do_req(1, mk(9, 3), 0);
    do_read(mk(3, 9), d, lat);
    chk(d == 1, "R1 row/col split read", d, 1);
    chk(lat == LAT_MISS, "R4 miss latency", lat, LAT_MISS);
    do_read(mk(9, 3), d, lat);
    chk(d == 0, "R1 swapped address read", d, 0);
    chk(mget(mk(3, 9)) == 1 && mget(mk(9, 3)) == 0, "R1 pin address", mget(mk(3, 9)), 1);
    chk(act_cnt - a0 == 4, "R6 activations on misses", act_cnt - a0, 4);
  endtask

  task automatic t_refresh_closes_page();
    bit d; int lat; int a0;
    wait_refresh();
    do_req(1, mk(42, 1), 1);
    wait_refresh();
    a0 = act_cnt;
    do_read(mk(42, 1), d, lat);
    chk(d == 1, "R9 data after refresh", d, 1);
    chk(act_cnt - a0 == 1, "R9 row reopened", act_cnt - a0, 1);
    chk(lat == LAT_MISS, "R9 reopen latency", lat, LAT_MISS);
  endtask

  task automatic t_refresh_interval();
    wait_refresh();
    wait_refresh();
    wait_refresh();
    chk(ref_gap == REF_INT, "R7 idle refresh spacing", ref_gap, REF_INT);
  endtask

  task automatic t_stream();
    int lcg = 12345, r0 = ref_cnt, bad = 0, lat;
    bit d;
    for (int i = 0; i < 700; i++) begin
      int a;
      lcg = lcg * 1103515245 + 12345;
      a = mk((lcg >>> 8) & 3, (lcg >>> 12) & 7);
      if (((lcg >>> 16) & 1) != 0) do_req(1, a, ((lcg >>> 20) & 1) != 0);
      else begin
        do_read(a, d, lat);
        if (d != (shadow.exists(a) ? shadow[a] : 1'b0)) bad++;
      end
    end
    chk(bad == 0, "R4 stream data", bad, 0);
    chk(ref_cnt > r0, "R7 refresh during stream", ref_cnt - r0, 1);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset();
    t_page_hit();
    t_split_miss();
    t_refresh_closes_page();
    t_refresh_interval();
    t_stream();
    repeat (5) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end
endmodule